// File: doc/BRIEF.md
# Iterative Logical Shift Execution Unit

This unit executes the two register-type logical shift instructions, shift-left and shift-right, over several clock cycles. It does not use a single-cycle barrel shifter. A control sequencer checks the opcode and function fields of an incoming instruction. When the sequencer accepts a start request, it captures the operand in an internal data register and the 5-bit shift amount in a down-counter. The data register then moves its contents by one bit per clock, with zero fill, until the counter runs out.

When the shift is complete, the unit presents the result together with the destination register index. It raises a done strobe and a register write-enable for exactly one cycle. An instruction that is not a supported shift is refused: the unit does not start and flags the instruction as unsupported instead. The register file and the rest of the datapath sit outside this block.

Top module: `iter_shift_unit`

## Requirements
- R1: An instruction is supported only when opcode_i is 6'h00. Within that opcode, funct_i 6'h00 selects shift-left logical and funct_i 6'h02 selects shift-right logical.
- R2: A start_i sampled while the unit is idle with a supported instruction captures operand_i, shamt_i and rd_i at that clock edge.
- R3: A left shift moves the data one bit toward the MSB per shift cycle and fills bit 0 with zero. The result equals operand_i << shamt_i.
- R4: A right shift moves the data one bit toward the LSB per shift cycle and fills the MSB with zero. The result equals operand_i >> shamt_i.
- R5: With shamt_i = N, done_o is high in the cycle N+2 after the cycle in which start_i was sampled high. There is one load cycle, then N shift cycles, then the write cycle.
- R6: With shamt_i = 0, no shift cycle occurs. The unchanged operand is written, and done_o is high one cycle after the load cycle.
- R7: A start_i with an unsupported opcode/funct pair does not start the unit. unsupported_o is high for exactly the next cycle, and done_o stays low.
- R8: done_o and wr_en_o are high together for exactly one cycle. In that cycle result_o holds the result and wr_addr_o holds the captured rd_i.
- R9: A start_i while a shift is in progress is ignored. The running operation finishes with its own result, latency and wr_addr_o.
- R10: After reset, done_o, wr_en_o and unsupported_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to execute the presented instruction |
| opcode_i | input | 6 | Opcode field |
| funct_i | input | 6 | Function field |
| shamt_i | input | 5 | Shift amount field |
| rd_i | input | 5 | Destination register index |
| operand_i | input | 32 | Value read from the source register |
| result_o | output | 32 | Shifted value, valid while done_o is high |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Destination register write-enable |
| wr_addr_o | output | 5 | Destination register index for the write |
| unsupported_o | output | 1 | One-cycle flag for a refused instruction |

## Verification
Several properties are checked by assertions on every cycle:
- done is a single-cycle pulse.
- Each single-bit step fills the vacated end with zero.
- The counter steps down by one per shift cycle.
- A zero shift amount goes straight from load to write.
- A refused instruction leaves the sequencer idle.
- The captured destination index stays put while the unit is busy.

Other behaviours only show up in the bench scenarios:
- The shifted values end-to-end.
- The exact latency for each shift amount.
- The decoding of each opcode/funct pair.
- Whether a second start during a busy shift is really ignored.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_WRITE = 2'd3
  } shift_state_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] FN_SLL   = 6'h00;
  localparam logic [5:0] FN_SRL   = 6'h02;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       supported_o,
  output logic       dir_right_o
);
  // R1: only the two logical shifts of the register-type opcode are accepted
  always_comb begin
    supported_o = (opcode_i == OP_RTYPE) && ((funct_i == FN_SLL) || (funct_i == FN_SRL));
    dir_right_o = (funct_i == FN_SRL);
  end
endmodule

// File: rtl/shift_datareg.sv
module shift_datareg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_ext_i,  // 1: take d_i, 0: one-bit shift
  input  logic              dir_right_i, // 1: right, 0: left
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (en_i) begin
      if (load_ext_i)     q_o <= d_i;
      else if (dir_right_i) q_o <= {1'b0, q_o[DATA_W-1:1]};
      else                q_o <= {q_o[DATA_W-2:0], 1'b0};
    end
  end

  p_left_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_ext_i && !dir_right_i) |=> (q_o[0] == 1'b0 && q_o[DATA_W-1:1] == $past(q_o[DATA_W-2:0])));

  p_right_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_ext_i && dir_right_i) |=> (q_o[DATA_W-1] == 1'b0 && q_o[DATA_W-2:0] == $past(q_o[DATA_W-1:1])));
endmodule

// File: rtl/shift_counter.sv
module shift_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] d_i,
  output logic             zero_o,
  output logic             one_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= d_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == CNT_W'(1));

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         supported_i,
  input  logic         cnt_zero_i,
  input  logic         cnt_one_i,
  output logic         accept_o,
  output logic         shift_en_o,
  output logic         write_o,
  output logic         refuse_o,
  output shift_state_e state_o
);
  shift_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i && supported_i) st_d = ST_LOAD;
      ST_LOAD:  st_d = cnt_zero_i ? ST_WRITE : ST_SHIFT;
      ST_SHIFT: if (cnt_one_i) st_d = ST_WRITE;
      ST_WRITE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign accept_o   = (st_q == ST_IDLE) && start_i && supported_i;
  assign refuse_o   = (st_q == ST_IDLE) && start_i && !supported_i;
  assign shift_en_o = (st_q == ST_SHIFT);
  assign write_o    = (st_q == ST_WRITE);
  assign state_o    = st_q;

  p_zero_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && cnt_zero_i) |=> (st_q == ST_WRITE));

  p_shift_loop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT && !cnt_one_i) |=> (st_q == ST_SHIFT));
endmodule

// File: rtl/iter_shift_unit.sv
module iter_shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [5:0]        opcode_i,
  input  logic [5:0]        funct_i,
  input  logic [$clog2(DATA_W)-1:0] shamt_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_addr_o,
  output logic              unsupported_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic supported, dir_right, dir_q;
  logic accept, shift_en, write, refuse;
  logic cnt_zero, cnt_one, unsup_q;
  logic [REG_W-1:0] rd_q;
  shift_state_e state;

  shift_decode u_decode (
    .opcode_i   (opcode_i),
    .funct_i    (funct_i),
    .supported_o(supported),
    .dir_right_o(dir_right)
  );

  shift_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .supported_i(supported),
    .cnt_zero_i (cnt_zero),
    .cnt_one_i  (cnt_one),
    .accept_o   (accept),
    .shift_en_o (shift_en),
    .write_o    (write),
    .refuse_o   (refuse),
    .state_o    (state)
  );

  shift_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .dec_i (shift_en),
    .d_i   (shamt_i),
    .zero_o(cnt_zero),
    .one_o (cnt_one)
  );

  shift_datareg #(.DATA_W(DATA_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (accept | shift_en),
    .load_ext_i (accept),
    .dir_right_i(dir_q),
    .d_i        (operand_i),
    .q_o        (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      rd_q    <= '0;
      unsup_q <= 1'b0;
    end else begin
      unsup_q <= refuse;
      if (accept) begin
        dir_q <= dir_right;
        rd_q  <= rd_i;
      end
    end
  end

  assign done_o        = write;
  assign wr_en_o       = write;
  assign wr_addr_o     = rd_q;
  assign unsupported_o = unsup_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_unsup_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> (state == ST_IDLE && !done_o));

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> $stable(wr_addr_o));
endmodule

// File: tb/iter_shift_unit_bench.sv
module iter_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  shamt = '0;
  logic [4:0]  rd = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        done, wr_en, unsup;
  logic [4:0]  wr_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iter_shift_unit u_iter_shift_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .funct_i(funct),
    .shamt_i(shamt), .rd_i(rd), .operand_i(operand), .result_o(result), .done_o(done),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .unsupported_o(unsup)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [4:0]  rd;
    logic [31:0] a;
    logic        bad;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h00, 5'd0,  5'd1,  32'h0000_0001, 1'b0},
    '{6'h00, 6'h00, 5'd1,  5'd2,  32'h8000_0001, 1'b0},
    '{6'h00, 6'h00, 5'd31, 5'd3,  32'hFFFF_FFFF, 1'b0},
    '{6'h00, 6'h02, 5'd31, 5'd4,  32'h8000_0000, 1'b0},
    '{6'h00, 6'h02, 5'd4,  5'd5,  32'hFFFF_FFFF, 1'b0},
    '{6'h00, 6'h02, 5'd0,  5'd6,  32'h1234_5678, 1'b0},
    '{6'h00, 6'h00, 5'd8,  5'd31, 32'hA5A5_A5A5, 1'b0},
    '{6'h23, 6'h00, 5'd3,  5'd8,  32'h0000_00FF, 1'b1},
    '{6'h00, 6'h03, 5'd3,  5'd9,  32'h0000_00FF, 1'b1},
    '{6'h00, 6'h20, 5'd3,  5'd10, 32'h0000_00FF, 1'b1}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_of(input logic [5:0] fn, input logic [31:0] a, input logic [4:0] sh);
    return (fn == 6'h02) ? (a >> sh) : (a << sh);
  endfunction

  // drive one instruction, return cycles until done (0 if none within limit)
  task automatic issue(input vec_t v, input bit poke_busy, output int lat, output int dones);
    @(negedge clk);
    opcode = v.op; funct = v.fn; shamt = v.sh; rd = v.rd; operand = v.a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0; dones = 0;
    for (int n = 1; n <= 40; n++) begin
      if (n > 1) @(negedge clk);
      if (poke_busy && n == 3) begin
        // R9: a second supported start while busy
        opcode = 6'h00; funct = 6'h02; shamt = 5'd1; rd = 5'd20; operand = 32'hDEAD_BEEF; start = 1'b1;
      end else if (poke_busy && n == 4) begin
        start = 1'b0;
      end
      if (done) begin
        dones++;
        if (lat == 0) begin
          lat = n;
          check(wr_en, "R8 wr_en with done", {31'd0, wr_en}, 32'd1);
          check(wr_addr == v.rd, "R8 wr_addr", {27'd0, wr_addr}, {27'd0, v.rd});
          check(result == expect_of(v.fn, v.a, v.sh), v.fn == 6'h02 ? "R4 result" : "R3 result",
                result, expect_of(v.fn, v.a, v.sh));
        end
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, dones;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!done && !wr_en && !unsup, "R10 reset flags", {29'd0, done, wr_en, unsup}, 32'd0);
    check(result == 32'd0, "R10 reset result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].bad) begin
        // R1 decode, R7 refusal
        @(negedge clk);
        opcode = VECS[i].op; funct = VECS[i].fn; shamt = VECS[i].sh; rd = VECS[i].rd;
        operand = VECS[i].a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(unsup, "R7 unsupported pulse", {31'd0, unsup}, 32'd1);
        @(negedge clk);
        check(!unsup, "R7 unsupported one cycle", {31'd0, unsup}, 32'd0);
        dones = 0;
        for (int n = 0; n < 40; n++) begin
          if (done) dones++;
          @(negedge clk);
        end
        check(dones == 0, "R7 no done on refusal", dones, 0);
      end else begin
        issue(VECS[i], 1'b0, lat, dones);
        check(lat == int'(VECS[i].sh) + 2, VECS[i].sh == 0 ? "R6 zero-shift latency" : "R5 latency",
              lat, int'(VECS[i].sh) + 2);
        check(dones == 1, "R8 single done", dones, 1);
        check(!unsup, "R1 supported not flagged", {31'd0, unsup}, 32'd0);
      end
    end

    // R9 start ignored while busy
    issue('{6'h00, 6'h00, 5'd10, 5'd7, 32'h0000_0001, 1'b0}, 1'b1, lat, dones);
    check(lat == 12, "R9 latency unaffected", lat, 12);
    check(dones == 1, "R9 single done", dones, 1);

    // R2 capture at accept: change inputs right after start
    @(negedge clk);
    opcode = 6'h00; funct = 6'h02; shamt = 5'd2; rd = 5'd12; operand = 32'h0000_0F00; start = 1'b1;
    @(negedge clk);
    start = 1'b0; operand = 32'hFFFF_FFFF; shamt = 5'd0; rd = 5'd0; funct = 6'h00;
    lat = 0;
    for (int n = 1; n <= 10; n++) begin
      if (n > 1) @(negedge clk);
      if (done && lat == 0) begin
        lat = n;
        check(result == 32'h0000_03C0, "R2 captured operand", result, 32'h0000_03C0);
        check(wr_addr == 5'd12, "R2 captured rd", {27'd0, wr_addr}, 32'd12);
      end
    end
    check(lat == 4, "R2 captured shamt", lat, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule